// File: doc/BRIEF.md
# Ternary CAM Lookup Engine

This block is a small full-ternary content-addressable memory. Each entry stores a data word and a per-bit mask word, so every stored bit acts as 0, 1 or don't-care. A command port accepts at most one operation per cycle, framed by a request strobe. The operations are: write an entry's data, write an entry's mask, write one of several global search masks, read back an entry's data or mask, and look up a key.

A lookup compares the key against every valid entry. The compare takes in the entry's own mask and the global mask picked by the select field. A priority encoder then returns the lowest matching index, with a hit flag and a result-valid pulse. The select field also comes back as a tag with the result, so a caller can route it to one of its result holders.

Several devices can be stacked in depth. A local-match output feeds the match input of lower-priority devices. A device whose match input is high keeps its hit flag low.

Top module: `tcam_lookup`

## Requirements
- R1: A lookup key matches an entry when every bit position whose entry mask bit is 1 equals the stored data bit. A mask bit of 0 makes that position don't-care. Op code 1 writes entry data and op code 2 writes entry mask, both at address `reqAddr`.
- R2: Op code 3 writes global mask register `reqSel`. All global mask registers reset to all ones. On a lookup (op code 0), the register chosen by `reqSel` also applies to the compare: a 0 bit in it is don't-care. Each register keeps its contents until it is written.
- R3: Every entry resets to invalid, and an invalid entry never matches. A data write (op code 1) marks the entry valid. A mask write alone does not mark it valid.
- R4: When several valid entries match, `respIndex` reports the lowest of their addresses.
- R5: `respValid` pulses for one cycle exactly two cycles after each lookup strobe, including lookups that miss. `respTag` carries that lookup's `reqSel`.
- R6: When a lookup matches and is not suppressed, `respHit` is 1 and `respIndex` gives the matching address. When it misses, `respHit` is 0 and `respIndex` is 0.
- R7: `matchOut` is high in the cycle after a lookup strobe if any local entry matches, whatever `matchIn` is. If `matchIn` is high in that same cycle, `respHit` is 0 and `respIndex` is 0, but `respValid` still pulses.
- R8: Op code 4 reads entry data and op code 5 reads entry mask. `rdAck` pulses and `rdData` carries the word two cycles after the strobe.
- R9: With `reqStb` low, or with op codes 6 or 7, nothing changes. No response is produced, and no entry or global mask is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqStb | input | 1 | Request strobe, one operation per cycle |
| reqOp | input | 3 | Operation code (0 lookup, 1 write data, 2 write mask, 3 write global mask, 4 read data, 5 read mask) |
| reqSel | input | 2 | Global mask select / result tag |
| reqAddr | input | 6 | Entry address |
| reqData | input | 72 | Write word or lookup key |
| matchIn | input | 1 | Higher-priority device has matched |
| respValid | output | 1 | Lookup completed |
| respHit | output | 1 | Lookup hit in this device |
| respIndex | output | 6 | Lowest matching entry address |
| respTag | output | 2 | Select value of the completed lookup |
| matchOut | output | 1 | Local match, to lower-priority devices |
| rdAck | output | 1 | Read data valid |
| rdData | output | 72 | Read data or mask word |

## Verification
The bound checker watches, on every cycle, the two-cycle latency of lookup results and read acknowledges, and that hit is only flagged together with a valid result. It also checks the index-zero rule on a miss, that a hit is suppressed after a high match input, and that at most one response appears at a time. The directed scenarios are needed to show the bit-level compare values: ternary don't-care positions, the effect of each global mask register, lowest-index priority, and that invalid entries are ignored. They also show that non-strobed or undefined requests leave the stored contents untouched, which is observable only through later lookups.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [2:0] {
    OP_LOOKUP  = 3'd0,
    OP_WR_DATA = 3'd1,
    OP_WR_MASK = 3'd2,
    OP_WR_GMSK = 3'd3,
    OP_RD_DATA = 3'd4,
    OP_RD_MASK = 3'd5
  } tcamOp_e;

  typedef struct packed {
    logic lookup;
    logic wrData;
    logic wrMask;
    logic wrGmask;
    logic rdData;
    logic rdMask;
  } ctrlStb_t;
endpackage

// File: rtl/tcam_ctrl.sv
module tcam_ctrl
  import tcam_pkg::*;
#(
  parameter int WIDTH  = 72,
  parameter int ADDR_W = 6,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStb,
  input  logic [2:0]        reqOp,
  input  logic [SEL_W-1:0]  reqSel,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WIDTH-1:0]  reqData,
  output ctrlStb_t          stb,
  output logic [SEL_W-1:0]  s1Sel,
  output logic [ADDR_W-1:0] s1Addr,
  output logic [WIDTH-1:0]  s1Data
);
  ctrlStb_t nextStb;

  always_comb begin
    nextStb = '0;
    if (reqStb) begin
      nextStb.lookup  = (reqOp == 3'(OP_LOOKUP));
      nextStb.wrData  = (reqOp == 3'(OP_WR_DATA));
      nextStb.wrMask  = (reqOp == 3'(OP_WR_MASK));
      nextStb.wrGmask = (reqOp == 3'(OP_WR_GMSK));
      nextStb.rdData  = (reqOp == 3'(OP_RD_DATA));
      nextStb.rdMask  = (reqOp == 3'(OP_RD_MASK));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stb    <= '0;
      s1Sel  <= '0;
      s1Addr <= '0;
      s1Data <= '0;
    end else begin
      stb <= nextStb;
      if (reqStb) begin
        s1Sel  <= reqSel;
        s1Addr <= reqAddr;
        s1Data <= reqData;
      end
    end
  end
endmodule

// File: rtl/tcam_datapath.sv
module tcam_datapath
  import tcam_pkg::*;
#(
  parameter int WIDTH   = 72,
  parameter int ENTRIES = 64,
  parameter int GMASKS  = 4,
  localparam int ADDR_W = $clog2(ENTRIES),
  localparam int SEL_W  = $clog2(GMASKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [SEL_W-1:0]  s1Sel,
  input  logic [ADDR_W-1:0] s1Addr,
  input  logic [WIDTH-1:0]  s1Data,
  input  logic              matchIn,
  output logic              respValid,
  output logic              respHit,
  output logic [ADDR_W-1:0] respIndex,
  output logic [SEL_W-1:0]  respTag,
  output logic              matchOut,
  output logic              rdAck,
  output logic [WIDTH-1:0]  rdData
);
  logic [WIDTH-1:0]  entData  [ENTRIES];
  logic [WIDTH-1:0]  entMask  [ENTRIES];
  logic [ENTRIES-1:0] entValid;
  logic [WIDTH-1:0]  gmask    [GMASKS];
  logic [WIDTH-1:0]  activeGmask;
  logic [ENTRIES-1:0] matchVec;
  logic [ADDR_W-1:0] firstIdx;
  logic              anyMatch;

  assign activeGmask = gmask[s1Sel];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign matchVec[e] = entValid[e] &&
      (((entData[e] ^ s1Data) & entMask[e] & activeGmask) == '0);
  end

  always_comb begin
    firstIdx = '0;
    anyMatch = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        firstIdx = ADDR_W'(i);
        anyMatch = 1'b1;
      end
    end
  end

  assign matchOut = stb.lookup && anyMatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        entData[i] <= '0;
        entMask[i] <= '0;
      end
      for (int g = 0; g < GMASKS; g++) gmask[g] <= '1;
    end else begin
      if (stb.wrData) begin
        entData[s1Addr]  <= s1Data;
        entValid[s1Addr] <= 1'b1;
      end
      if (stb.wrMask)  entMask[s1Addr] <= s1Data;
      if (stb.wrGmask) gmask[s1Sel]    <= s1Data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respIndex <= '0;
      respTag   <= '0;
      rdAck     <= 1'b0;
      rdData    <= '0;
    end else begin
      respValid <= stb.lookup;
      rdAck     <= stb.rdData || stb.rdMask;
      if (stb.lookup) begin
        respHit   <= anyMatch && !matchIn;
        respIndex <= (anyMatch && !matchIn) ? firstIdx : '0;
        respTag   <= s1Sel;
      end else begin
        respHit   <= 1'b0;
      end
      if (stb.rdData) rdData <= entData[s1Addr];
      if (stb.rdMask) rdData <= entMask[s1Addr];
    end
  end
endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup
  import tcam_pkg::*;
#(
  parameter int WIDTH   = 72,
  parameter int ENTRIES = 64,
  parameter int GMASKS  = 4,
  localparam int ADDR_W = $clog2(ENTRIES),
  localparam int SEL_W  = $clog2(GMASKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStb,
  input  logic [2:0]        reqOp,
  input  logic [SEL_W-1:0]  reqSel,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WIDTH-1:0]  reqData,
  input  logic              matchIn,
  output logic              respValid,
  output logic              respHit,
  output logic [ADDR_W-1:0] respIndex,
  output logic [SEL_W-1:0]  respTag,
  output logic              matchOut,
  output logic              rdAck,
  output logic [WIDTH-1:0]  rdData
);
  ctrlStb_t          stb;
  logic [SEL_W-1:0]  s1Sel;
  logic [ADDR_W-1:0] s1Addr;
  logic [WIDTH-1:0]  s1Data;

  tcam_ctrl #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqStb(reqStb), .reqOp(reqOp), .reqSel(reqSel),
    .reqAddr(reqAddr), .reqData(reqData), .stb(stb), .s1Sel(s1Sel),
    .s1Addr(s1Addr), .s1Data(s1Data)
  );

  tcam_datapath #(.WIDTH(WIDTH), .ENTRIES(ENTRIES), .GMASKS(GMASKS)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .s1Sel(s1Sel), .s1Addr(s1Addr),
    .s1Data(s1Data), .matchIn(matchIn), .respValid(respValid),
    .respHit(respHit), .respIndex(respIndex), .respTag(respTag),
    .matchOut(matchOut), .rdAck(rdAck), .rdData(rdData)
  );
endmodule

// File: rtl/tcam_lookup_chk.sv
module tcam_lookup_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqStb,
  input logic [2:0]        reqOp,
  input logic              matchIn,
  input logic              respValid,
  input logic              respHit,
  input logic [ADDR_W-1:0] respIndex,
  input logic              matchOut,
  input logic              rdAck
);
  assert_result_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ($past(reqStb, 2) && $past(reqOp, 2) == 3'd0));

  assert_hit_has_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> respValid);

  assert_miss_index_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (respIndex == '0));

  assert_cascade_suppress_R7: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> (!$past(matchIn) && $past(matchOut)));

  assert_matchout_after_lookup_R7: assert property (@(posedge clk) disable iff (!rstN)
    matchOut |-> ($past(reqStb) && $past(reqOp) == 3'd0));

  assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdAck |-> ($past(reqStb, 2) && ($past(reqOp, 2) == 3'd4 || $past(reqOp, 2) == 3'd5)));

  assert_single_response_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({respValid, rdAck}));
endmodule

bind tcam_lookup tcam_lookup_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .reqStb(reqStb), .reqOp(reqOp), .matchIn(matchIn),
  .respValid(respValid), .respHit(respHit), .respIndex(respIndex),
  .matchOut(matchOut), .rdAck(rdAck)
);

// File: tb/test_tcam_lookup.sv
`timescale 1ns/1ps
module test_tcam_lookup;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqStb = 1'b0;
  logic [2:0]  reqOp = 3'd0;
  logic [1:0]  reqSel = 2'd0;
  logic [5:0]  reqAddr = 6'd0;
  logic [71:0] reqData = '0;
  logic        matchIn = 1'b0;
  logic        respValid, respHit, matchOut, rdAck;
  logic [5:0]  respIndex;
  logic [1:0]  respTag;
  logic [71:0] rdData;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam logic [71:0] KD = 72'hA5_0123_4567_89AB_CDEF;
  localparam logic [71:0] KT = 72'h3C_0000_0000_0000_1200;
  localparam logic [71:0] KP = 72'h77_7777_7777_7777_7777;
  localparam logic [71:0] K2 = 72'h11_2222_3333_4444_5555;
  localparam logic [71:0] K3 = 72'h66_0F0F_0F0F_0F0F_0F0F;
  localparam logic [71:0] ONES = '1;

  always #4 clk = ~clk;

  tcam_lookup i_tcam_lookup (
    .clk(clk), .rstN(rstN), .reqStb(reqStb), .reqOp(reqOp), .reqSel(reqSel),
    .reqAddr(reqAddr), .reqData(reqData), .matchIn(matchIn),
    .respValid(respValid), .respHit(respHit), .respIndex(respIndex),
    .respTag(respTag), .matchOut(matchOut), .rdAck(rdAck), .rdData(rdData)
  );

  task automatic chk(string req, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic stbVal, logic [2:0] op, logic [1:0] sel,
                       logic [5:0] addr, logic [71:0] data);
    @(negedge clk);
    reqStb = stbVal; reqOp = op; reqSel = sel; reqAddr = addr; reqData = data;
    @(negedge clk);
    reqStb = 1'b0;
  endtask

  task automatic lookup(string req, logic [71:0] key, logic [1:0] sel, logic mi,
                        logic expLocal, logic expHit, logic [5:0] expIdx);
    issue(1'b1, 3'd0, sel, 6'd0, key);
    matchIn = mi;
    chk({req, " matchOut"}, 72'(matchOut), 72'(expLocal));
    @(negedge clk);
    matchIn = 1'b0;
    chk({req, " respValid"}, 72'(respValid), 72'd1);
    chk({req, " respHit"}, 72'(respHit), 72'(expHit));
    chk({req, " respIndex"}, 72'(respIndex), 72'(expIdx));
    chk({req, " respTag"}, 72'(respTag), 72'(sel));
  endtask

  task automatic readEntry(string req, logic [2:0] op, logic [5:0] addr, logic [71:0] exp);
    issue(1'b1, op, 2'd0, addr, '0);
    @(negedge clk);
    chk({req, " rdAck"}, 72'(rdAck), 72'd1);
    chk({req, " rdData"}, rdData, exp);
  endtask

  task automatic testReset();
    chk("R5 reset respValid", 72'(respValid), 72'd0);
    chk("R8 reset rdAck", 72'(rdAck), 72'd0);
    chk("R7 reset matchOut", 72'(matchOut), 72'd0);
    lookup("R3 empty array miss", '0, 2'd0, 1'b0, 1'b0, 1'b0, 6'd0);
    @(negedge clk);
    chk("R5 single pulse", 72'(respValid), 72'd0);
  endtask

  task automatic testExact();
    issue(1'b1, 3'd2, 2'd0, 6'd5, ONES);
    issue(1'b1, 3'd1, 2'd0, 6'd5, KD);
    lookup("R1 exact hit", KD, 2'd0, 1'b0, 1'b1, 1'b1, 6'd5);
    lookup("R6 one-bit miss", KD ^ 72'd1, 2'd0, 1'b0, 1'b0, 1'b0, 6'd0);
  endtask

  task automatic testTernary();
    issue(1'b1, 3'd1, 2'd0, 6'd9, KT);
    issue(1'b1, 3'd2, 2'd0, 6'd9, ~72'hFF);
    lookup("R1 dont-care bits hit", KT | 72'h34, 2'd0, 1'b0, 1'b1, 1'b1, 6'd9);
    lookup("R1 compared bit miss", KT ^ 72'h100, 2'd0, 1'b0, 1'b0, 1'b0, 6'd0);
  endtask

  task automatic testPriority();
    issue(1'b1, 3'd2, 2'd0, 6'd30, ONES);
    issue(1'b1, 3'd1, 2'd0, 6'd30, KP);
    lookup("R4 single entry", KP, 2'd1, 1'b0, 1'b1, 1'b1, 6'd30);
    issue(1'b1, 3'd2, 2'd0, 6'd20, ONES);
    issue(1'b1, 3'd1, 2'd0, 6'd20, KP);
    lookup("R4 lowest index wins", KP, 2'd3, 1'b0, 1'b1, 1'b1, 6'd20);
  endtask

  task automatic testGlobalMask();
    logic [71:0] key = KD ^ (72'd1 << 70);
    lookup("R2 reset gmask compares all", key, 2'd2, 1'b0, 1'b0, 1'b0, 6'd0);
    issue(1'b1, 3'd3, 2'd2, 6'd0, ~(72'd1 << 70));
    lookup("R2 gmask2 masks bit70", key, 2'd2, 1'b0, 1'b1, 1'b1, 6'd5);
    lookup("R2 gmask1 unchanged", key, 2'd1, 1'b0, 1'b0, 1'b0, 6'd0);
  endtask

  task automatic testInvalid();
    issue(1'b1, 3'd2, 2'd0, 6'd40, '0);
    lookup("R3 mask-only entry stays invalid", K3, 2'd0, 1'b0, 1'b0, 1'b0, 6'd0);
    readEntry("R8 read mask entry40", 3'd5, 6'd40, '0);
  endtask

  task automatic testCascade();
    lookup("R7 matchIn suppresses hit", KD, 2'd0, 1'b1, 1'b1, 1'b0, 6'd0);
    lookup("R7 matchIn on a miss", K3, 2'd0, 1'b1, 1'b0, 1'b0, 6'd0);
  endtask

  task automatic testReads();
    readEntry("R8 read data entry5", 3'd4, 6'd5, KD);
    readEntry("R8 read mask entry9", 3'd5, 6'd9, ~72'hFF);
    readEntry("R8 read data entry9", 3'd4, 6'd9, KT);
  endtask

  task automatic testIgnored();
    issue(1'b1, 3'd2, 2'd0, 6'd50, ONES);
    issue(1'b0, 3'd1, 2'd0, 6'd50, K2);
    @(negedge clk);
    chk("R9 no strobe no response", 72'({respValid, rdAck}), 72'd0);
    lookup("R9 unstrobed write ignored", K2, 2'd0, 1'b0, 1'b0, 1'b0, 6'd0);
    issue(1'b1, 3'd6, 2'd0, 6'd50, K2);
    @(negedge clk);
    chk("R9 op6 no response", 72'({respValid, rdAck}), 72'd0);
    issue(1'b1, 3'd7, 2'd1, 6'd50, '0);
    @(negedge clk);
    chk("R9 op7 no response", 72'({respValid, rdAck}), 72'd0);
    lookup("R9 op6 wrote nothing", K2, 2'd0, 1'b0, 1'b0, 1'b0, 6'd0);
    lookup("R9 op7 left gmask1", KD ^ (72'd1 << 70), 2'd1, 1'b0, 1'b0, 1'b0, 6'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testExact();
    testTernary();
    testPriority();
    testGlobalMask();
    testInvalid();
    testCascade();
    testReads();
    testIgnored();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule